// File: doc/BRIEF.md
# JTAG Debug Transport Bridge

This block is a JTAG test access port whose data registers reach a debug bus. The 16-state TAP controller is clocked by TCK. A 5-bit instruction register selects one of four data registers: a fixed identification word, a transport control/status word, a debug-bus access register, or a one-bit bypass stage. Scanning the access register does two things. On capture it returns the status and read data of the previous bus operation. On update it may start a new read or write on a valid/ready request port, which is answered through a response port.

Error reporting is sticky. A scan that begins while a bus operation is still in flight latches a busy status. A response flagged as an error latches a failure status. While either is latched, every new bus operation is dropped. The only way to clear it is a write of bit 16 in the control/status word. TDI data is shifted in and TDO data is shifted out least significant bit first. TDO changes on the falling edge of TCK.

The whole block, including the bus ports, runs in the TCK domain. Reset is synchronous and active high.

Top module: `dtm_jtag_top`

## Requirements
- R1: After `rst`, the instruction register holds opcode 0x01. A data scan then returns the IDCODE parameter on `tdo`, bit 0 first.
- R2: Five consecutive TCK rising edges with `tms` high put the controller in Test-Logic-Reset. The instruction register then selects opcode 0x01.
- R3: The instruction register is 5 bits wide, loaded through Shift-IR and Update-IR. The opcodes are:
  - 0x01: identification word.
  - 0x10: control/status word.
  - 0x11: access register.
  - Any other opcode: a 1-bit bypass stage that captures 0.
- R4: The control/status word captures:
  - bits 3:0: the VERSION parameter.
  - bits 9:4: ABITS.
  - bits 11:10: the sticky status.
  - all other bits: zero.
- R5: The access register is {address (ABITS bits), data [33:2], op [1:0]}. On Update-DR, op 1 issues one read request and op 2 issues one write request, with the scanned address and data. Op 0 issues nothing. `req_valid` then stays high, with address, data and op held, until `req_ready`.
- R6: Capture-DR of the access register loads bits 1:0 with the status and bits 33:2 with the data of the most recent response. Status encodings are 0 = success, 2 = failure, 3 = busy.
- R7: A capture of the access register while a request is pending or unanswered latches status 3. The status stays at 3, and updates issue no request, until it is cleared.
- R8: A response with `rsp_err` high latches status 2. It is sticky in the same way as busy.
- R9: An update of the control/status word with bit 16 set returns the sticky status to 0. Later operations then proceed.
- R10: `tdo_en` is high only while the controller is in Shift-IR or Shift-DR. `tdo` and `tdo_en` change on falling TCK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, clocks the whole block |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | TDO drive enable |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus request accepted |
| req_addr | output | ABITS | Request address |
| req_data | output | 32 | Write data |
| req_op | output | 2 | 1 read, 2 write |
| rsp_valid | input | 1 | Response strobe, always accepted |
| rsp_data | input | 32 | Read data of the response |
| rsp_err | input | 1 | Response reports an error |

## Verification
The bench builds the block with ABITS of 7, so the access scan is 41 bits long and address 0x7F is in range. The bench's responder treats 0x7F as the address that fails. With a VERSION of 1 and an odd IDCODE, each control and identification field has a distinct, checkable value. The responder latency is set at run time. A short latency exercises clean read-after-write. A latency of 60 cycles guarantees that a back-to-back scan meets an unanswered request and latches busy.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int IR_W = 5;
    localparam logic [IR_W-1:0] OPC_IDENT = 5'h01;
    localparam logic [IR_W-1:0] OPC_CTRL  = 5'h10;
    localparam logic [IR_W-1:0] OPC_ACC   = 5'h11;
    localparam int CLR_BIT = 16;

    typedef enum logic [3:0] {
        T_RESET, T_IDLE,
        T_SELD, T_CAPD, T_SHD, T_X1D, T_PSD, T_X2D, T_UPD,
        T_SELI, T_CAPI, T_SHI, T_X1I, T_PSI, T_X2I, T_UPI
    } tap_e;

    typedef enum logic [1:0] {
        BOP_NOP = 2'd0, BOP_RD = 2'd1, BOP_WR = 2'd2, BOP_RSV = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        ST_OK = 2'd0, ST_RSV = 2'd1, ST_FAIL = 2'd2, ST_BUSY = 2'd3
    } bus_st_e;

    function automatic tap_e tap_step(input tap_e s, input logic m);
        case (s)
            T_RESET: return m ? T_RESET : T_IDLE;
            T_IDLE:  return m ? T_SELD  : T_IDLE;
            T_SELD:  return m ? T_SELI  : T_CAPD;
            T_CAPD:  return m ? T_X1D   : T_SHD;
            T_SHD:   return m ? T_X1D   : T_SHD;
            T_X1D:   return m ? T_UPD   : T_PSD;
            T_PSD:   return m ? T_X2D   : T_PSD;
            T_X2D:   return m ? T_UPD   : T_SHD;
            T_UPD:   return m ? T_SELD  : T_IDLE;
            T_SELI:  return m ? T_RESET : T_CAPI;
            T_CAPI:  return m ? T_X1I   : T_SHI;
            T_SHI:   return m ? T_X1I   : T_SHI;
            T_X1I:   return m ? T_UPI   : T_PSI;
            T_PSI:   return m ? T_X2I   : T_PSI;
            T_X2I:   return m ? T_UPI   : T_SHI;
            default: return m ? T_SELD  : T_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/dtm_tap_fsm.sv
module dtm_tap_fsm
    import dtm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tms,
    output tap_e state
);
    always_ff @(posedge clk) begin
        if (rst) state <= T_RESET;
        else     state <= tap_step(state, tms);
    end

    // checker-side count of consecutive high TMS edges, saturating
    logic [2:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst)              hi_cnt <= '0;
        else if (!tms)        hi_cnt <= '0;
        else if (hi_cnt != 7) hi_cnt <= hi_cnt + 3'd1;
    end

    p_tms_reset_r2: assert property (@(posedge clk) disable iff (rst)
        (hi_cnt >= 3'd5) |-> (state == T_RESET));
endmodule

// File: rtl/dtm_ir.sv
module dtm_ir
    import dtm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tap_e             state,
    input  logic             tdi,
    output logic [IR_W-1:0]  ir,
    output logic             ir_lsb
);
    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge clk) begin
        if (rst || state == T_RESET) begin
            ir    <= OPC_IDENT;
            ir_sh <= '0;
        end else begin
            case (state)
                T_CAPI:  ir_sh <= IR_W'(1);
                T_SHI:   ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                T_UPI:   ir    <= ir_sh;
                default: ;
            endcase
        end
    end

    assign ir_lsb = ir_sh[0];

    p_ir_reset_r1: assert property (@(posedge clk) disable iff (rst)
        (state == T_RESET) |=> (ir == OPC_IDENT));
endmodule

// File: rtl/dtm_bus_ctrl.sv
module dtm_bus_ctrl
    import dtm_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             probe,
    input  logic             go,
    input  bus_op_e          go_op,
    input  logic [ABITS-1:0] go_addr,
    input  logic [31:0]      go_data,
    input  logic             clr,
    output bus_st_e          sticky,
    output bus_st_e          view_st,
    output logic [31:0]      rdata,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [ABITS-1:0] req_addr,
    output logic [31:0]      req_data,
    output logic [1:0]       req_op,
    input  logic             rsp_valid,
    input  logic [31:0]      rsp_data,
    input  logic             rsp_err
);
    logic    wait_rsp, busy_now, rsp_take;
    bus_st_e st_nxt;

    assign busy_now = req_valid || wait_rsp;
    assign rsp_take = rsp_valid && wait_rsp;
    assign view_st  = (sticky == ST_OK && busy_now) ? ST_BUSY : sticky;

    always_comb begin
        st_nxt = sticky;
        if (probe && sticky == ST_OK && busy_now)  st_nxt = ST_BUSY;
        if (rsp_take && rsp_err && st_nxt == ST_OK) st_nxt = ST_FAIL;
        if (clr)                                   st_nxt = ST_OK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky    <= ST_OK;
            req_valid <= 1'b0;
            wait_rsp  <= 1'b0;
            rdata     <= '0;
            req_addr  <= '0;
            req_data  <= '0;
            req_op    <= '0;
        end else begin
            sticky <= st_nxt;
            if (req_valid && req_ready) begin
                req_valid <= 1'b0;
                wait_rsp  <= 1'b1;
            end
            if (rsp_take) begin
                wait_rsp <= 1'b0;
                rdata    <= rsp_data;
            end
            if (go && sticky == ST_OK && !busy_now
                && (go_op == BOP_RD || go_op == BOP_WR)) begin
                req_valid <= 1'b1;
                req_addr  <= go_addr;
                req_data  <= go_data;
                req_op    <= go_op;
            end
        end
    end

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_data) && $stable(req_op)));
    p_launch_clean_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> ($past(sticky) == ST_OK));
    p_busy_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (sticky == ST_BUSY && !clr) |=> (sticky == ST_BUSY));
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (sticky == ST_FAIL && !clr) |=> (sticky == ST_FAIL));
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sticky == ST_OK));
endmodule

// File: rtl/dtm_dr.sv
module dtm_dr
    import dtm_pkg::*;
#(
    parameter int          ABITS   = 7,
    parameter logic [31:0] IDCODE  = 32'h1C0F_FEE1,
    parameter logic [3:0]  VERSION = 4'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  tap_e             state,
    input  logic [IR_W-1:0]  ir,
    input  logic             tdi,
    input  bus_st_e          sticky,
    input  bus_st_e          view_st,
    input  logic [31:0]      rdata,
    output logic             dr_lsb,
    output logic             probe,
    output logic             go,
    output bus_op_e          go_op,
    output logic [ABITS-1:0] go_addr,
    output logic [31:0]      go_data,
    output logic             clr
);
    localparam int DW = ABITS + 34;

    logic [DW-1:0] sh, sh_nxt;
    int unsigned   len;

    always_comb begin
        case (ir)
            OPC_IDENT, OPC_CTRL: len = 32;
            OPC_ACC:             len = DW;
            default:             len = 1;
        endcase
        sh_nxt          = sh >> 1;
        sh_nxt[len - 1] = tdi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (state == T_CAPD) begin
            case (ir)
                OPC_IDENT: sh <= DW'(IDCODE);
                OPC_CTRL:  sh <= DW'({20'd0, sticky, 6'(ABITS), VERSION});
                OPC_ACC:   sh <= {{ABITS{1'b0}}, rdata, view_st};
                default:   sh <= '0;
            endcase
        end else if (state == T_SHD) begin
            sh <= sh_nxt;
        end
    end

    assign dr_lsb  = sh[0];
    assign probe   = (state == T_CAPD) && (ir == OPC_ACC);
    assign go      = (state == T_UPD) && (ir == OPC_ACC);
    assign go_op   = bus_op_e'(sh[1:0]);
    assign go_data = sh[33:2];
    assign go_addr = sh[DW-1:34];
    assign clr     = (state == T_UPD) && (ir == OPC_CTRL) && sh[CLR_BIT];
endmodule

// File: rtl/dtm_jtag_top.sv
module dtm_jtag_top
    import dtm_pkg::*;
#(
    parameter int          ABITS   = 7,
    parameter logic [31:0] IDCODE  = 32'h1C0F_FEE1,
    parameter logic [3:0]  VERSION = 4'd1
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [ABITS-1:0] req_addr,
    output logic [31:0]      req_data,
    output logic [1:0]       req_op,
    input  logic             rsp_valid,
    input  logic [31:0]      rsp_data,
    input  logic             rsp_err
);
    tap_e             state;
    logic [IR_W-1:0]  ir;
    logic             ir_lsb, dr_lsb, probe, go, clr;
    bus_op_e          go_op;
    logic [ABITS-1:0] go_addr;
    logic [31:0]      go_data, rdata;
    bus_st_e          sticky, view_st;

    dtm_tap_fsm u_fsm (.clk(tck), .rst(rst), .tms(tms), .state(state));

    dtm_ir u_ir (.clk(tck), .rst(rst), .state(state), .tdi(tdi),
                 .ir(ir), .ir_lsb(ir_lsb));

    dtm_dr #(.ABITS(ABITS), .IDCODE(IDCODE), .VERSION(VERSION)) u_dr (
        .clk(tck), .rst(rst), .state(state), .ir(ir), .tdi(tdi),
        .sticky(sticky), .view_st(view_st), .rdata(rdata),
        .dr_lsb(dr_lsb), .probe(probe), .go(go), .go_op(go_op),
        .go_addr(go_addr), .go_data(go_data), .clr(clr));

    dtm_bus_ctrl #(.ABITS(ABITS)) u_bus (
        .clk(tck), .rst(rst), .probe(probe), .go(go), .go_op(go_op),
        .go_addr(go_addr), .go_data(go_data), .clr(clr),
        .sticky(sticky), .view_st(view_st), .rdata(rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_op(req_op), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_err(rsp_err));

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == T_SHD) || (state == T_SHI);
            tdo    <= (state == T_SHI) ? ir_lsb
                    : (state == T_SHD) ? dr_lsb : 1'b0;
        end
    end

    p_tdo_en_r10: assert property (@(posedge tck) disable iff (rst)
        tdo_en |-> (state == T_SHD || state == T_SHI));
endmodule

// File: tb/tb_dtm_jtag_top.sv
module tb_dtm_jtag_top;
    localparam int          ABITS = 7;
    localparam int          DW    = ABITS + 34;
    localparam logic [31:0] IDC   = 32'h1C0F_FEE1;

    logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en, req_valid, req_ready = 1'b1;
    logic [ABITS-1:0] req_addr;
    logic [31:0] req_data, rsp_data = '0;
    logic [1:0]  req_op;
    logic rsp_valid = 1'b0, rsp_err = 1'b0;

    int n_chk = 0, n_fail = 0, n_req = 0, lat = 3;
    bit finished = 0;

    always #5 tck = ~tck;

    dtm_jtag_top #(.ABITS(ABITS), .IDCODE(IDC), .VERSION(4'd1)) dut (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_op(req_op), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_err(rsp_err));

    // debug-bus responder model
    logic [31:0] mem [4];
    bit pend = 0;
    int cnt = 0;
    logic [31:0] r_val;
    bit r_err;
    always @(negedge tck) begin
        rsp_valid = 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                rsp_valid = 1'b1; rsp_data = r_val; rsp_err = r_err; pend = 0;
            end else cnt--;
        end else if (req_valid) begin
            n_req++;
            pend  = 1;
            cnt   = lat;
            r_err = (req_addr == 7'h7F);
            r_val = '0;
            if (!r_err && req_op == 2'd2) mem[req_addr[1:0]] = req_data;
            if (!r_err && req_op == 2'd1) r_val = mem[req_addr[1:0]];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic en);
        @(negedge tck); #1;
        tms = m; tdi = d; o = tdo; en = tdo_en;
        @(posedge tck);
    endtask

    task automatic idle(input int n);
        logic o, e;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, o, e);
    endtask

    task automatic scan_ir(input logic [4:0] opc);
        logic o, e;
        step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < 5; i++) step(i == 4, opc[i], o, e);
        step(1, 0, o, e); step(0, 0, o, e);
    endtask

    task automatic scan_dr(input logic [63:0] din, input int len,
                           output logic [63:0] dout, output bit all_en);
        logic o, e;
        dout = '0; all_en = 1;
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < len; i++) begin
            step(i == len - 1, din[i], o, e);
            dout[i] = o;
            if (!e) all_en = 0;
        end
        step(1, 0, o, e); step(0, 0, o, e);
    endtask

    function automatic logic [63:0] acc(input logic [6:0] a, input logic [31:0] d,
                                        input logic [1:0] op);
        return 64'({a, d, op});
    endfunction

    task automatic t_reset();
        logic [63:0] q; bit en;
        chk(tdo_en == 1'b0 && req_valid == 1'b0, "R10 reset outputs idle", {tdo_en, req_valid}, 0);
        idle(1);
        scan_dr(0, 32, q, en);
        chk(q[31:0] == IDC, "R1 identification after reset", q, IDC);
        chk(en, "R10 tdo_en high through shift", en, 1);
        chk(tdo_en == 1'b0, "R10 tdo_en low in idle", tdo_en, 0);
    endtask

    task automatic t_tms_reset();
        logic [63:0] q; bit en; logic o, e;
        scan_ir(5'h10);
        for (int i = 0; i < 5; i++) step(1, 0, o, e);
        step(0, 0, o, e);
        scan_dr(0, 32, q, en);
        chk(q[31:0] == IDC, "R2 five high TMS reselects identification", q, IDC);
    endtask

    task automatic t_ctrl_bypass();
        logic [63:0] q; bit en;
        scan_ir(5'h10);
        scan_dr(0, 32, q, en);
        chk(q[31:0] == 32'h71, "R4 control word fields", q, 32'h71);
        scan_ir(5'h1F);
        scan_dr(64'b01, 2, q, en);
        chk(q[1:0] == 2'b10, "R3 bypass one-bit delay", q[1:0], 2'b10);
    endtask

    task automatic t_write_read();
        logic [63:0] q; bit en;
        lat = 3;
        scan_ir(5'h11);
        scan_dr(acc(7'h03, 32'h1234_5678, 2'd2), DW, q, en);
        idle(10);
        chk(n_req == 1, "R5 one request per write update", n_req, 1);
        scan_dr(acc(7'h03, 0, 2'd1), DW, q, en);
        chk(q[1:0] == 2'd0, "R6 status after write", q[1:0], 0);
        idle(10);
        scan_dr(acc(7'h00, 0, 2'd0), DW, q, en);
        chk(q[33:2] == 32'h1234_5678, "R6 read data captured", q[33:2], 32'h1234_5678);
        chk(q[1:0] == 2'd0, "R6 status after read", q[1:0], 0);
        idle(10);
        chk(n_req == 2, "R5 nop issues no request", n_req, 2);
    endtask

    task automatic t_busy();
        logic [63:0] q; bit en;
        int base = n_req;
        lat = 60;
        scan_dr(acc(7'h01, 32'hAAAA_0001, 2'd2), DW, q, en);
        scan_dr(acc(7'h02, 32'hBBBB_0002, 2'd2), DW, q, en);
        chk(q[1:0] == 2'd3, "R7 busy on early scan", q[1:0], 3);
        idle(90);
        chk(n_req == base + 1, "R7 op ignored while busy", n_req, base + 1);
        scan_dr(acc(7'h01, 0, 2'd1), DW, q, en);
        chk(q[1:0] == 2'd3, "R7 busy is sticky", q[1:0], 3);
        idle(10);
        chk(n_req == base + 1, "R7 read ignored while busy", n_req, base + 1);
        scan_ir(5'h10);
        scan_dr(64'h1_0000, 32, q, en);
        scan_dr(0, 32, q, en);
        chk(q[11:10] == 2'd0, "R9 clear returns status to zero", q[11:10], 0);
        lat = 3;
        scan_ir(5'h11);
        scan_dr(acc(7'h01, 0, 2'd1), DW, q, en);
        idle(10);
        scan_dr(0, DW, q, en);
        chk(q[33:2] == 32'hAAAA_0001 && q[1:0] == 0, "R9 operation after clear",
            q[33:0], {32'hAAAA_0001, 2'b00});
    endtask

    task automatic t_error();
        logic [63:0] q; bit en;
        int base;
        scan_dr(acc(7'h7F, 32'h5, 2'd2), DW, q, en);
        idle(10);
        scan_dr(acc(7'h02, 32'h77, 2'd2), DW, q, en);
        chk(q[1:0] == 2'd2, "R8 error status", q[1:0], 2);
        base = n_req;
        idle(10);
        chk(n_req == base, "R8 op ignored after error", n_req, base);
        scan_ir(5'h10);
        scan_dr(0, 32, q, en);
        chk(q[11:10] == 2'd2, "R4 R8 control shows sticky error", q[11:10], 2);
        scan_dr(64'h1_0000, 32, q, en);
        scan_dr(0, 32, q, en);
        chk(q[11:10] == 2'd0, "R9 error cleared", q[11:10], 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hang expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mem[i] = '0;
        repeat (3) @(posedge tck);
        #1 rst = 1'b0;
        t_reset();
        t_tms_reset();
        t_ctrl_bypass();
        t_write_read();
        t_busy();
        t_error();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule